// File: doc/BRIEF.md
# Shadow Region Register Access Filter

This block is the register front end for a set of per-channel DMA control registers that several software owners share. One physical copy of the channel registers exists. It can be reached through a global view and through one aliased view per region. Each region owns a programmable ownership mask with one bit per channel. The mask filters every read and write made through that region's view, bit by bit, so that an owner only sees and changes the channels assigned to it. A second, narrower set of masks assigns the quick-channel event register to regions in the same way.

The same DMA ownership mask picks which completed channels raise the region's interrupt. When a channel finishes, it sets its pending bit. Each region's interrupt line is the registered OR of pending, interrupt-enable and that region's mask. The global view is never filtered, and it is the only place where ownership masks can be changed.

Top module: `shadow_region_filter`

## Requirements
- R1: After synchronous reset, every ownership mask, the event, interrupt-enable, pending and quick-event registers, and every interrupt output are 0.
- R2: The word address is {view, offset}, with view in the upper 3 bits and offset in the lower 4 bits. View 0 is the global view and reads or writes every bit unfiltered. The offsets are: 0 event, 1 interrupt-enable, 2 pending, 3 quick-event (8 bits), 4+m DMA mask of region m, and 8+m quick mask of region m.
- R3: A read of offsets 0 to 2 through view m+1 (region m) returns 0 in each bit whose region-m DMA mask bit is 0, and the real value in each bit whose mask bit is 1.
- R4: A write through region m's view changes only the bits whose region-m mask bit is 1. Every other bit of the target register keeps its value, even when the same write carries enabled bits.
- R5: Ownership masks are written only through the global view. A write to a mask offset through a region view has no effect, and a read of a mask offset through a region view returns 0.
- R6: A 1 on done_i[n] sets pending bit n at the next edge. Writing 1 to a pending bit clears it, subject to R3/R4 filtering. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R7: irq_o[m] equals the OR over n of (pending[n] & int-enable[n] & DMA-mask[m][n]), registered, so it follows a change of any of these one clock edge after that change is stored.
- R8: The quick-event register (offset 3) is filtered in region views by that region's 8-bit quick mask in the same way as R3/R4.
- R9: Unmapped offsets (12 to 15) and views above 4 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 7 | Word address: view in bits 6:4, register offset in bits 3:0 |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational and filtered by view |
| done_i | input | 32 | Per-channel completion pulses that set pending bits |
| irq_o | output | 4 | Per-region completion interrupt, registered |

## Verification
Two functions can hit the same pending bit in one cycle: a channel completion that sets it and a software write-one-to-clear that removes it. The bench drives done_i for a channel in the same cycle as a global clear of that bit, then reads pending back and expects the bit to remain set. It also clears through a region view while a bit the region does not own stays pending. It then checks that the interrupt of the owning region follows one edge later and that the other regions stay quiet.

// File: rtl/sra_pkg.sv
package sra_pkg;

    // Register offsets inside one view
    localparam int OFS_EVT       = 0;
    localparam int OFS_IEN       = 1;
    localparam int OFS_PEND      = 2;
    localparam int OFS_QEVT      = 3;
    localparam int OFS_MASK_BASE = 4;

    typedef enum logic [1:0] {
        VIEW_GLOBAL = 2'd0,
        VIEW_REGION = 2'd1,
        VIEW_NONE   = 2'd2
    } view_kind_e;

    typedef enum logic [2:0] {
        REG_EVT   = 3'd0,
        REG_IEN   = 3'd1,
        REG_PEND  = 3'd2,
        REG_QEVT  = 3'd3,
        REG_DMASK = 3'd4,
        REG_QMASK = 3'd5,
        REG_NONE  = 3'd6
    } reg_kind_e;

    typedef struct packed {
        view_kind_e kind;
        logic [7:0] region;
        reg_kind_e  target;
        logic [7:0] mask_idx;
    } access_t;

    // Replace only the bits selected by keep_new
    function automatic logic [31:0] merge_bits(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [31:0] keep_new);
        return (old_v & ~keep_new) | (new_v & keep_new);
    endfunction

endpackage

// File: rtl/sra_addr_decode.sv
module sra_addr_decode
    import sra_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int VIEW_W      = 3,
    parameter int OFS_W       = 4
) (
    input  logic [VIEW_W+OFS_W-1:0] addr_i,
    output access_t                 acc_o
);
    localparam int ADDR_W = VIEW_W + OFS_W;

    logic [VIEW_W-1:0] view;
    logic [OFS_W-1:0]  ofs;
    int                o;
    int                v;

    assign view = addr_i[ADDR_W-1:OFS_W];
    assign ofs  = addr_i[OFS_W-1:0];

    always_comb begin
        v = int'(view);
        o = int'(ofs);
        acc_o          = '0;
        acc_o.kind     = VIEW_NONE;
        acc_o.target   = REG_NONE;
        acc_o.region   = '0;
        acc_o.mask_idx = '0;

        if (v == 0) begin
            acc_o.kind = VIEW_GLOBAL;
        end else if (v <= NUM_REGIONS) begin
            acc_o.kind   = VIEW_REGION;
            acc_o.region = 8'(v - 1);
        end

        if (o == OFS_EVT) begin
            acc_o.target = REG_EVT;
        end else if (o == OFS_IEN) begin
            acc_o.target = REG_IEN;
        end else if (o == OFS_PEND) begin
            acc_o.target = REG_PEND;
        end else if (o == OFS_QEVT) begin
            acc_o.target = REG_QEVT;
        end else if (o >= OFS_MASK_BASE && o < OFS_MASK_BASE + NUM_REGIONS) begin
            acc_o.target   = REG_DMASK;
            acc_o.mask_idx = 8'(o - OFS_MASK_BASE);
        end else if (o >= OFS_MASK_BASE + NUM_REGIONS &&
                     o < OFS_MASK_BASE + 2 * NUM_REGIONS) begin
            acc_o.target   = REG_QMASK;
            acc_o.mask_idx = 8'(o - OFS_MASK_BASE - NUM_REGIONS);
        end
    end

endmodule

// File: rtl/sra_mask_bank.sv
module sra_mask_bank
    import sra_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int NUM_CH      = 32,
    parameter int NUM_QCH     = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en_i,
    input  access_t                             acc_i,
    input  logic [31:0]                         wdata_i,
    output logic [NUM_REGIONS-1:0][NUM_CH-1:0]  dmask_o,
    output logic [NUM_REGIONS-1:0][NUM_QCH-1:0] qmask_o
);
    logic global_wr;

    // Only the unfiltered view may change ownership
    assign global_wr = wr_en_i && (acc_i.kind == VIEW_GLOBAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            dmask_o <= '0;
            qmask_o <= '0;
        end else if (global_wr) begin
            for (int r = 0; r < NUM_REGIONS; r++) begin
                if (acc_i.mask_idx == 8'(r)) begin
                    if (acc_i.target == REG_DMASK) dmask_o[r] <= wdata_i[NUM_CH-1:0];
                    if (acc_i.target == REG_QMASK) qmask_o[r] <= wdata_i[NUM_QCH-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/sra_chan_regs.sv
module sra_chan_regs
    import sra_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int NUM_QCH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en_i,
    input  access_t            acc_i,
    input  logic [31:0]        wdata_i,
    input  logic [NUM_CH-1:0]  wmask_i,
    input  logic [NUM_QCH-1:0] qwmask_i,
    input  logic [NUM_CH-1:0]  done_i,
    output logic [NUM_CH-1:0]  evt_o,
    output logic [NUM_CH-1:0]  ien_o,
    output logic [NUM_CH-1:0]  pend_o,
    output logic [NUM_QCH-1:0] qevt_o
);
    logic [NUM_CH-1:0]  wd;
    logic [NUM_CH-1:0]  evt_n, ien_n, pend_n, pend_clr;
    logic [NUM_QCH-1:0] qevt_n;
    logic [31:0]        evt_ext, ien_ext, wd_ext, m_ext;
    logic [31:0]        evt_mrg, ien_mrg;

    assign wd = wdata_i[NUM_CH-1:0];

    always_comb begin
        evt_ext = '0;  evt_ext[NUM_CH-1:0] = evt_o;
        ien_ext = '0;  ien_ext[NUM_CH-1:0] = ien_o;
        wd_ext  = '0;  wd_ext[NUM_CH-1:0]  = wd;
        m_ext   = '0;  m_ext[NUM_CH-1:0]   = wmask_i;
        evt_mrg = merge_bits(evt_ext, wd_ext, m_ext);
        ien_mrg = merge_bits(ien_ext, wd_ext, m_ext);

        evt_n    = evt_o;
        ien_n    = ien_o;
        qevt_n   = qevt_o;
        pend_clr = '0;

        if (wr_en_i) begin
            case (acc_i.target)
                REG_EVT:  evt_n    = evt_mrg[NUM_CH-1:0];
                REG_IEN:  ien_n    = ien_mrg[NUM_CH-1:0];
                REG_PEND: pend_clr = wd & wmask_i;
                REG_QEVT: qevt_n   = (qevt_o & ~qwmask_i) |
                                     (wdata_i[NUM_QCH-1:0] & qwmask_i);
                default:  ;
            endcase
        end
        // Completion set has priority over a software clear
        pend_n = (pend_o & ~pend_clr) | done_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_o  <= '0;
            ien_o  <= '0;
            pend_o <= '0;
            qevt_o <= '0;
        end else begin
            evt_o  <= evt_n;
            ien_o  <= ien_n;
            pend_o <= pend_n;
            qevt_o <= qevt_n;
        end
    end

endmodule

// File: rtl/sra_irq_reduce.sv
module sra_irq_reduce #(
    parameter int NUM_REGIONS = 4,
    parameter int NUM_CH      = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_CH-1:0]                  pend_i,
    input  logic [NUM_CH-1:0]                  ien_i,
    input  logic [NUM_REGIONS-1:0][NUM_CH-1:0] dmask_i,
    output logic [NUM_REGIONS-1:0]             irq_o
);
    logic [NUM_CH-1:0]      live;
    logic [NUM_REGIONS-1:0] hit;

    assign live = pend_i & ien_i;

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        assign hit[r] = |(live & dmask_i[r]);
    end

    always_ff @(posedge clk) begin
        if (rst) irq_o <= '0;
        else     irq_o <= hit;
    end

endmodule

// File: rtl/shadow_region_filter.sv
module shadow_region_filter
    import sra_pkg::*;
#(
    parameter  int NUM_REGIONS = 4,
    parameter  int NUM_CH      = 32,
    parameter  int NUM_QCH     = 8,
    localparam int VIEW_W      = $clog2(NUM_REGIONS + 1),
    localparam int OFS_W       = $clog2(OFS_MASK_BASE + 2 * NUM_REGIONS),
    localparam int ADDR_W      = VIEW_W + OFS_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic                   wr_en_i,
    input  logic [31:0]            wdata_i,
    output logic [31:0]            rdata_o,
    input  logic [NUM_CH-1:0]      done_i,
    output logic [NUM_REGIONS-1:0] irq_o
);
    access_t                              acc;
    logic [NUM_REGIONS-1:0][NUM_CH-1:0]   dmask;
    logic [NUM_REGIONS-1:0][NUM_QCH-1:0]  qmask;
    logic [NUM_CH-1:0]                    sel_m;
    logic [NUM_QCH-1:0]                   sel_q;
    logic [NUM_CH-1:0]                    evt_q, ien_q, pend_q;
    logic [NUM_QCH-1:0]                   qevt_q;
    logic [NUM_CH-1:0]                    mask_rd_d;
    logic [NUM_QCH-1:0]                   mask_rd_q;

    sra_addr_decode #(
        .NUM_REGIONS (NUM_REGIONS),
        .VIEW_W      (VIEW_W),
        .OFS_W       (OFS_W)
    ) dec_i (
        .addr_i (addr_i),
        .acc_o  (acc)
    );

    sra_mask_bank #(
        .NUM_REGIONS (NUM_REGIONS),
        .NUM_CH      (NUM_CH),
        .NUM_QCH     (NUM_QCH)
    ) masks_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (wr_en_i),
        .acc_i   (acc),
        .wdata_i (wdata_i),
        .dmask_o (dmask),
        .qmask_o (qmask)
    );

    // Bit filter for the current view
    always_comb begin
        sel_m     = '0;
        sel_q     = '0;
        mask_rd_d = '0;
        mask_rd_q = '0;
        if (acc.kind == VIEW_GLOBAL) begin
            sel_m = '1;
            sel_q = '1;
        end
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (acc.kind == VIEW_REGION && acc.region == 8'(r)) begin
                sel_m = dmask[r];
                sel_q = qmask[r];
            end
            if (acc.mask_idx == 8'(r)) begin
                mask_rd_d = dmask[r];
                mask_rd_q = qmask[r];
            end
        end
    end

    sra_chan_regs #(
        .NUM_CH  (NUM_CH),
        .NUM_QCH (NUM_QCH)
    ) chan_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en_i  (wr_en_i),
        .acc_i    (acc),
        .wdata_i  (wdata_i),
        .wmask_i  (sel_m),
        .qwmask_i (sel_q),
        .done_i   (done_i),
        .evt_o    (evt_q),
        .ien_o    (ien_q),
        .pend_o   (pend_q),
        .qevt_o   (qevt_q)
    );

    sra_irq_reduce #(
        .NUM_REGIONS (NUM_REGIONS),
        .NUM_CH      (NUM_CH)
    ) irq_i (
        .clk     (clk),
        .rst     (rst),
        .pend_i  (pend_q),
        .ien_i   (ien_q),
        .dmask_i (dmask),
        .irq_o   (irq_o)
    );

    // Filtered read path
    always_comb begin
        rdata_o = '0;
        case (acc.target)
            REG_EVT:  rdata_o[NUM_CH-1:0]  = evt_q  & sel_m;
            REG_IEN:  rdata_o[NUM_CH-1:0]  = ien_q  & sel_m;
            REG_PEND: rdata_o[NUM_CH-1:0]  = pend_q & sel_m;
            REG_QEVT: rdata_o[NUM_QCH-1:0] = qevt_q & sel_q;
            REG_DMASK: if (acc.kind == VIEW_GLOBAL) rdata_o[NUM_CH-1:0]  = mask_rd_d;
            REG_QMASK: if (acc.kind == VIEW_GLOBAL) rdata_o[NUM_QCH-1:0] = mask_rd_q;
            default: ;
        endcase
    end

endmodule

// File: rtl/shadow_region_filter_chk.sv
module shadow_region_filter_chk #(
    parameter int NUM_REGIONS = 4,
    parameter int NUM_CH      = 32,
    parameter int NUM_QCH     = 8,
    parameter int VIEW_W      = 3,
    parameter int OFS_W       = 4
) (
    input logic                                clk,
    input logic                                rst,
    input logic [VIEW_W+OFS_W-1:0]             addr_i,
    input logic                                wr_en_i,
    input logic [31:0]                         rdata_o,
    input logic [NUM_CH-1:0]                   done_i,
    input logic [NUM_REGIONS-1:0]              irq_o,
    input logic [NUM_CH-1:0]                   ien,
    input logic [NUM_CH-1:0]                   pend,
    input logic [NUM_REGIONS-1:0][NUM_CH-1:0]  dmask,
    input logic [NUM_REGIONS-1:0][NUM_QCH-1:0] qmask
);
    logic [VIEW_W-1:0] view;
    logic [OFS_W-1:0]  ofs;
    logic              in_region;
    logic [NUM_CH-1:0] own;

    assign view      = addr_i[VIEW_W+OFS_W-1:OFS_W];
    assign ofs       = addr_i[OFS_W-1:0];
    assign in_region = (view != '0) && (int'(view) <= NUM_REGIONS);

    always_comb begin
        own = '0;
        for (int r = 0; r < NUM_REGIONS; r++)
            if (int'(view) == r + 1) own = dmask[r];
    end

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_irq
        AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> irq_o[r] == |($past(pend) & $past(ien) & $past(dmask[r]))); // R7
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (irq_o == '0 && pend == '0 && dmask == '0 && qmask == '0)); // R1

    AST_DONE_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        (done_i != '0) |=> ((pend & $past(done_i)) == $past(done_i))); // R6

    AST_REGION_READ_FILTERED: assert property (@(posedge clk) disable iff (rst)
        (in_region && int'(ofs) < 3) |-> ((rdata_o[NUM_CH-1:0] & ~own) == '0)); // R3

    AST_REGION_NO_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && view != '0) |=> (dmask == $past(dmask) && qmask == $past(qmask))); // R5

    AST_REGION_WRITE_CONFINED: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && in_region && int'(ofs) == 1) |=> (((ien ^ $past(ien)) & ~$past(own)) == '0)); // R4

endmodule

bind shadow_region_filter shadow_region_filter_chk #(
    .NUM_REGIONS (NUM_REGIONS),
    .NUM_CH      (NUM_CH),
    .NUM_QCH     (NUM_QCH),
    .VIEW_W      (VIEW_W),
    .OFS_W       (OFS_W)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .rdata_o (rdata_o),
    .done_i  (done_i),
    .irq_o   (irq_o),
    .ien     (ien_q),
    .pend    (pend_q),
    .dmask   (dmask),
    .qmask   (qmask)
);

// File: tb/shadow_region_filter_tb.sv
`timescale 1ns/1ps
module shadow_region_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [31:0] done_i = '0;
    logic [3:0]  irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    shadow_region_filter dut_i (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .done_i  (done_i),
        .irq_o   (irq_o)
    );

    // Entry: {is_write, addr[7:0], wdata, expected, req}
    localparam int NV = 26;
    localparam logic [76:0] VEC [NV] = '{
        {1'b1, 8'h04, 32'h0000_00FF, 32'h0, 4'd2},         // R2 region0 DMA mask
        {1'b1, 8'h05, 32'h0000_FF00, 32'h0, 4'd2},         // R2 region1 DMA mask
        {1'b1, 8'h08, 32'h0000_000F, 32'h0, 4'd8},         // R8 region0 quick mask
        {1'b0, 8'h04, 32'h0, 32'h0000_00FF, 4'd2},         // R2 mask readback
        {1'b1, 8'h00, 32'hAAAA_AAAA, 32'h0, 4'd2},         // R2 global event write
        {1'b0, 8'h10, 32'h0, 32'h0000_00AA, 4'd3},         // R3 region0 view
        {1'b0, 8'h20, 32'h0, 32'h0000_AA00, 4'd3},         // R3 region1 view
        {1'b1, 8'h10, 32'h5555_5555, 32'h0, 4'd4},         // R4 region0 write
        {1'b0, 8'h00, 32'h0, 32'hAAAA_AA55, 4'd4},         // R4 only low byte changed
        {1'b0, 8'h10, 32'h0, 32'h0000_0055, 4'd3},         // R3
        {1'b1, 8'h34, 32'hFFFF_FFFF, 32'h0, 4'd5},         // R5 region2 mask write
        {1'b0, 8'h04, 32'h0, 32'h0000_00FF, 4'd5},         // R5 unchanged
        {1'b0, 8'h14, 32'h0, 32'h0, 4'd5},                 // R5 region read of mask
        {1'b1, 8'h13, 32'h0000_00FF, 32'h0, 4'd8},         // R8 region0 quick write
        {1'b0, 8'h03, 32'h0, 32'h0000_000F, 4'd8},         // R8
        {1'b0, 8'h13, 32'h0, 32'h0000_000F, 4'd8},         // R8
        {1'b0, 8'h23, 32'h0, 32'h0, 4'd8},                 // R8 region1 owns none
        {1'b1, 8'h0F, 32'hFFFF_FFFF, 32'h0, 4'd9},         // R9 unmapped offset
        {1'b0, 8'h0F, 32'h0, 32'h0, 4'd9},                 // R9
        {1'b1, 8'h50, 32'h0, 32'h0, 4'd9},                 // R9 view 5 write
        {1'b0, 8'h00, 32'h0, 32'hAAAA_AA55, 4'd9},         // R9 unchanged
        {1'b0, 8'h70, 32'h0, 32'h0, 4'd9},                 // R9 view 7 read
        {1'b1, 8'h01, 32'hFFFF_FFFF, 32'h0, 4'd2},         // R2 global int-enable
        {1'b0, 8'h21, 32'h0, 32'h0000_FF00, 4'd3},         // R3
        {1'b1, 8'h41, 32'h0, 32'h0, 4'd4},                 // R4 region3 owns none
        {1'b0, 8'h01, 32'h0, 32'hFFFF_FFFF, 4'd4}          // R4 nothing cleared
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i  = a;
        wdata_i = d;
        wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input string req, input logic [6:0] a, input logic [31:0] exp);
        addr_i  = a;
        wr_en_i = 1'b0;
        #1;
        check(req, rdata_o, exp);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd("R1", 7'h00, 32'h0);
        rd("R1", 7'h01, 32'h0);
        rd("R1", 7'h02, 32'h0);
        rd("R1", 7'h03, 32'h0);
        rd("R1", 7'h04, 32'h0);
        rd("R1", 7'h08, 32'h0);
        check("R1", {28'h0, irq_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][76]) begin
                wr(VEC[i][75:68], VEC[i][67:36]);
            end else begin
                rd($sformatf("R%0d", VEC[i][3:0]), VEC[i][75:68], VEC[i][35:4]);
            end
        end

        // R6/R7: completion on channel 3, owned by region 0
        @(negedge clk);
        done_i = 32'h0000_0008;
        @(negedge clk);
        done_i = '0;
        check("R7", {28'h0, irq_o}, 32'h0);         // pending stored, irq one edge later
        @(negedge clk);
        check("R7", {28'h0, irq_o}, 32'h1);

        // channel 9, owned by region 1
        done_i = 32'h0000_0200;
        @(negedge clk);
        done_i = '0;
        @(negedge clk);
        check("R7", {28'h0, irq_o}, 32'h3);

        // R6 region1 clears all: only bit 9 is its own
        wr(7'h22, 32'hFFFF_FFFF);
        rd("R6", 7'h02, 32'h0000_0008);
        @(negedge clk);
        check("R7", {28'h0, irq_o}, 32'h1);

        // R6 set and clear of bit 4 in the same cycle: set wins
        @(negedge clk);
        addr_i  = 7'h02;
        wdata_i = 32'h0000_0010;
        wr_en_i = 1'b1;
        done_i  = 32'h0000_0010;
        @(negedge clk);
        wr_en_i = 1'b0;
        done_i  = '0;
        rd("R6", 7'h02, 32'h0000_0018);
        rd("R3", 7'h32, 32'h0);

        // R7 mask change drops region 0 interrupt one edge after storage
        wr(7'h04, 32'h0);
        check("R7", {28'h0, irq_o}, 32'h1);
        @(negedge clk);
        check("R7", {28'h0, irq_o}, 32'h0);

        // R1 reset mid-run clears everything again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd("R1", 7'h02, 32'h0);
        rd("R1", 7'h05, 32'h0);
        check("R1", {28'h0, irq_o}, 32'h0);

        finish_run();
    end

endmodule